// File: doc/BRIEF.md
# Debug Trigger Chain Evaluator

This block holds ten hardware debug triggers. It turns their raw comparator matches into final fire decisions for the instruction that is being presented. Each trigger has a configuration word and a compare value, both loaded through a write port that takes one trigger per cycle. Each trigger watches one operand channel: fetch, load or store. It compares that operand against its value with an equal, unsigned greater-or-equal or unsigned less-than test.

The triggers form five fixed pairs, (2p, 2p+1). The chain bit of a pair is written with the lower trigger's configuration. When a pair is chained, its two triggers fire together or not at all, and they are vetoed outright when their timing bits disagree. The store/store pair can never be chained. The fired set is reduced to three flags: "trap before this instruction" (timing 0), "trap after this instruction" (timing 1), and "enter debug mode" (action 1, where action 0 means a breakpoint exception). Delivering the hits down the pipeline and performing the trap are handled by the surrounding logic.

Top module: `dbg_trig_eval`

## Requirements
- R1: After reset every trigger is disabled, every pair is unchained, and no fire bit or flag is set whatever the operands are.
- R2: With cfg_we high, trigger cfg_idx takes its enable, match type, select, timing, action and value from the port at the clock edge, and they are in effect from the next cycle. Indices 10 to 15 change nothing.
- R3: Match type codes: 0 is operand equal to value, 2 is operand >= value (unsigned), 3 is operand < value (unsigned), and 1 never matches.
- R4: Channels by trigger: 0, 1, 6 and 8 watch fetch; 2, 3 and 7 watch store; 4, 5 and 9 watch load. With select 0 a trigger compares the address (fetch_addr, store_addr, load_addr). With select 1 it compares the data: fetch_insn for fetch, store_data for store. A load trigger with select 1 never matches.
- R5: A trigger fires only while insn_valid is high and the trigger is enabled.
- R6: The chain bit of pair p is written only by a write to trigger 2p. A write to trigger 2p+1 leaves it unchanged. In a chained pair, both triggers fire only when both match, and otherwise neither fires.
- R7: In a chained pair whose two timing bits differ, neither trigger fires.
- R8: Pair 1 (triggers 2 and 3, store/store) ignores its chain bit, and its triggers fire independently.
- R9: trap_before is high when any fired trigger has timing 0. trap_after is high when any fired trigger has timing 1.
- R10: enter_debug is high when any fired trigger has action 1.
- R11: In a chained pair with either trigger disabled, neither trigger fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 4 | Trigger index to write |
| cfg_enable | input | 1 | Trigger enable |
| cfg_mtype | input | 2 | Match type code |
| cfg_sel | input | 1 | 0 address, 1 data |
| cfg_timing | input | 1 | 0 trap before, 1 trap after |
| cfg_action | input | 1 | 1 debug mode, 0 breakpoint |
| cfg_chain | input | 1 | Pair chain bit (lower trigger only) |
| cfg_value | input | DATA_W | Compare value |
| insn_valid | input | 1 | Instruction present qualifier |
| fetch_addr | input | DATA_W | Fetch address |
| fetch_insn | input | DATA_W | Fetched instruction word |
| load_addr | input | DATA_W | Load address |
| store_addr | input | DATA_W | Store address |
| store_data | input | DATA_W | Store data |
| fire | output | 10 | Per-trigger fire vector |
| trap_before | output | 1 | Trap before the instruction |
| trap_after | output | 1 | Trap after the instruction |
| enter_debug | output | 1 | Fired trigger requests debug mode |

## Verification
The bench builds the block with DATA_W set to 16 and leaves the trigger count at its fixed ten. With 16-bit operands, the unsigned range edges (value minus one, the value itself, and all ones) are easy to drive and check by hand. The pairing map, chaining and timing veto do not depend on the width, so every pair kind (fetch/fetch, store/store, load, fetch/load) is exercised with its real structure.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;

    localparam int NUM_PAIRS  = 5;
    localparam int NUM_TRIG   = 2 * NUM_PAIRS;
    localparam int IDX_W      = $clog2(NUM_TRIG);
    localparam int STORE_PAIR = 1;

    typedef enum logic [1:0] {
        SRC_FETCH = 2'd0,
        SRC_LOAD  = 2'd1,
        SRC_STORE = 2'd2
    } src_e;

    typedef enum logic [1:0] {
        MT_EQ   = 2'd0,
        MT_RSVD = 2'd1,
        MT_GE   = 2'd2,
        MT_LT   = 2'd3
    } mtype_e;

    typedef struct packed {
        logic   enable;
        mtype_e mtype;
        logic   sel;
        logic   timing;
        logic   action;
    } trig_ctl_t;

    // Fixed channel of each trigger: pairs are fetch/fetch, store/store,
    // load/load, fetch/store, fetch/load.
    function automatic src_e src_of(input int t);
        case (t)
            0, 1, 6, 8: return SRC_FETCH;
            2, 3, 7:    return SRC_STORE;
            default:    return SRC_LOAD;
        endcase
    endfunction

    function automatic bit pair_chainable(input int p);
        return p != STORE_PAIR;
    endfunction

endpackage

// File: rtl/dbg_trig_cfg.sv
module dbg_trig_cfg
    import dbg_trig_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_we,
    input  logic [IDX_W-1:0]        cfg_idx,
    input  trig_ctl_t               cfg_ctl,
    input  logic                    cfg_chain,
    input  logic [DATA_W-1:0]       cfg_value,
    output trig_ctl_t               ctl_q   [NUM_TRIG],
    output logic [DATA_W-1:0]       value_q [NUM_TRIG],
    output logic [NUM_PAIRS-1:0]    chain_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int t = 0; t < NUM_TRIG; t++) begin
                ctl_q[t]   <= '0;
                value_q[t] <= '0;
            end
            chain_q <= '0;
        end else if (cfg_we) begin
            for (int t = 0; t < NUM_TRIG; t++) begin
                if (cfg_idx == IDX_W'(t)) begin
                    ctl_q[t]   <= cfg_ctl;
                    value_q[t] <= cfg_value;
                    if ((t % 2) == 0) chain_q[t/2] <= cfg_chain;
                end
            end
        end
    end

endmodule

// File: rtl/dbg_trig_cmp.sv
module dbg_trig_cmp
    import dbg_trig_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter bit DATA_OK = 1'b1
) (
    input  logic              insn_valid,
    input  logic              enable,
    input  mtype_e            mtype,
    input  logic              sel,
    input  logic [DATA_W-1:0] value,
    input  logic [DATA_W-1:0] addr_op,
    input  logic [DATA_W-1:0] data_op,
    output logic              hit
);

    logic [DATA_W-1:0] operand;
    logic              cmp_ok;
    logic              sel_ok;

    assign operand = sel ? data_op : addr_op;
    assign sel_ok  = !(sel && !DATA_OK);

    always_comb begin
        unique case (mtype)
            MT_EQ:   cmp_ok = (operand == value);
            MT_GE:   cmp_ok = (operand >= value);
            MT_LT:   cmp_ok = (operand <  value);
            default: cmp_ok = 1'b0;
        endcase
    end

    assign hit = insn_valid && enable && sel_ok && cmp_ok;

endmodule

// File: rtl/dbg_trig_pair.sv
module dbg_trig_pair #(
    parameter bit CHAINABLE = 1'b1
) (
    input  logic hit_lo,
    input  logic hit_hi,
    input  logic chain,
    input  logic tim_lo,
    input  logic tim_hi,
    output logic fire_lo,
    output logic fire_hi
);

    logic chained;
    logic joint;

    assign chained = chain && CHAINABLE;
    assign joint   = hit_lo && hit_hi && (tim_lo == tim_hi);
    assign fire_lo = chained ? joint : hit_lo;
    assign fire_hi = chained ? joint : hit_hi;

endmodule

// File: rtl/dbg_trig_eval.sv
module dbg_trig_eval
    import dbg_trig_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cfg_we,
    input  logic [IDX_W-1:0]           cfg_idx,
    input  logic                       cfg_enable,
    input  logic [1:0]                 cfg_mtype,
    input  logic                       cfg_sel,
    input  logic                       cfg_timing,
    input  logic                       cfg_action,
    input  logic                       cfg_chain,
    input  logic [DATA_W-1:0]          cfg_value,
    input  logic                       insn_valid,
    input  logic [DATA_W-1:0]          fetch_addr,
    input  logic [DATA_W-1:0]          fetch_insn,
    input  logic [DATA_W-1:0]          load_addr,
    input  logic [DATA_W-1:0]          store_addr,
    input  logic [DATA_W-1:0]          store_data,
    output logic [NUM_TRIG-1:0]        fire,
    output logic                       trap_before,
    output logic                       trap_after,
    output logic                       enter_debug
);

    trig_ctl_t            cfg_ctl;
    trig_ctl_t            ctl_q   [NUM_TRIG];
    logic [DATA_W-1:0]    value_q [NUM_TRIG];
    logic [NUM_PAIRS-1:0] chain_q;
    logic [DATA_W-1:0]    addr_op [NUM_TRIG];
    logic [DATA_W-1:0]    data_op [NUM_TRIG];
    logic [NUM_TRIG-1:0]  hit;
    logic [NUM_TRIG-1:0]  en_vec;
    logic [NUM_TRIG-1:0]  tim_vec;
    logic [NUM_TRIG-1:0]  act_vec;

    assign cfg_ctl = '{enable: cfg_enable, mtype: mtype_e'(cfg_mtype),
                       sel: cfg_sel, timing: cfg_timing, action: cfg_action};

    dbg_trig_cfg #(.DATA_W(DATA_W)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_ctl   (cfg_ctl),
        .cfg_chain (cfg_chain),
        .cfg_value (cfg_value),
        .ctl_q     (ctl_q),
        .value_q   (value_q),
        .chain_q   (chain_q)
    );

    for (genvar t = 0; t < NUM_TRIG; t++) begin : g_trig
        localparam src_e SRC = src_of(t);

        if (SRC == SRC_FETCH) begin : g_fetch
            assign addr_op[t] = fetch_addr;
            assign data_op[t] = fetch_insn;
        end else if (SRC == SRC_STORE) begin : g_store
            assign addr_op[t] = store_addr;
            assign data_op[t] = store_data;
        end else begin : g_load
            assign addr_op[t] = load_addr;
            assign data_op[t] = load_addr;
        end

        assign en_vec[t]  = ctl_q[t].enable;
        assign tim_vec[t] = ctl_q[t].timing;
        assign act_vec[t] = ctl_q[t].action;

        dbg_trig_cmp #(
            .DATA_W  (DATA_W),
            .DATA_OK (SRC != SRC_LOAD)
        ) u_cmp (
            .insn_valid (insn_valid),
            .enable     (ctl_q[t].enable),
            .mtype      (ctl_q[t].mtype),
            .sel        (ctl_q[t].sel),
            .value      (value_q[t]),
            .addr_op    (addr_op[t]),
            .data_op    (data_op[t]),
            .hit        (hit[t])
        );
    end

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        dbg_trig_pair #(.CHAINABLE(pair_chainable(p))) u_pair (
            .hit_lo  (hit[2*p]),
            .hit_hi  (hit[2*p+1]),
            .chain   (chain_q[p]),
            .tim_lo  (tim_vec[2*p]),
            .tim_hi  (tim_vec[2*p+1]),
            .fire_lo (fire[2*p]),
            .fire_hi (fire[2*p+1])
        );
    end

    assign trap_before = |(fire & ~tim_vec);
    assign trap_after  = |(fire & tim_vec);
    assign enter_debug = |(fire & act_vec);

endmodule

// File: rtl/dbg_trig_eval_chk.sv
module dbg_trig_eval_chk
    import dbg_trig_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 cfg_we,
    input logic [IDX_W-1:0]     cfg_idx,
    input logic                 cfg_enable,
    input logic                 insn_valid,
    input logic [NUM_TRIG-1:0]  fire,
    input logic                 trap_before,
    input logic                 trap_after,
    input logic                 enter_debug,
    input logic [NUM_TRIG-1:0]  en_vec,
    input logic [NUM_TRIG-1:0]  tim_vec,
    input logic [NUM_TRIG-1:0]  act_vec,
    input logic [NUM_PAIRS-1:0] chain_q
);

    assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_idx < IDX_W'(NUM_TRIG)) |=> en_vec[$past(cfg_idx)] == $past(cfg_enable));

    assert_no_fire_idle_R5: assert property (@(posedge clk) disable iff (rst)
        !insn_valid |-> fire == '0);

    assert_fire_needs_enable_R5: assert property (@(posedge clk) disable iff (rst)
        (fire & ~en_vec) == '0);

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair_chk
        if (pair_chainable(p)) begin : g_ch
            assert_chain_joint_R6: assert property (@(posedge clk) disable iff (rst)
                chain_q[p] |-> fire[2*p] == fire[2*p+1]);
            assert_timing_veto_R7: assert property (@(posedge clk) disable iff (rst)
                (chain_q[p] && tim_vec[2*p] != tim_vec[2*p+1]) |-> !fire[2*p] && !fire[2*p+1]);
            assert_disabled_pair_R11: assert property (@(posedge clk) disable iff (rst)
                (chain_q[p] && !(en_vec[2*p] && en_vec[2*p+1])) |-> !fire[2*p] && !fire[2*p+1]);
        end
    end

    assert_trap_flag_R9: assert property (@(posedge clk) disable iff (rst)
        (fire != '0) |-> (trap_before || trap_after));

    assert_before_source_R9: assert property (@(posedge clk) disable iff (rst)
        trap_before |-> (fire & ~tim_vec) != '0);

    assert_debug_source_R10: assert property (@(posedge clk) disable iff (rst)
        enter_debug |-> (fire & act_vec) != '0);

endmodule

bind dbg_trig_eval dbg_trig_eval_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_we      (cfg_we),
    .cfg_idx     (cfg_idx),
    .cfg_enable  (cfg_enable),
    .insn_valid  (insn_valid),
    .fire        (fire),
    .trap_before (trap_before),
    .trap_after  (trap_after),
    .enter_debug (enter_debug),
    .en_vec      (en_vec),
    .tim_vec     (tim_vec),
    .act_vec     (act_vec),
    .chain_q     (chain_q)
);

// File: tb/dbg_trig_eval_tb.sv
module dbg_trig_eval_tb;
    import dbg_trig_pkg::*;

    localparam int DW = 16;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           cfg_we = 1'b0;
    logic [IDX_W-1:0] cfg_idx = '0;
    logic           cfg_enable = 1'b0;
    logic [1:0]     cfg_mtype = '0;
    logic           cfg_sel = 1'b0, cfg_timing = 1'b0, cfg_action = 1'b0, cfg_chain = 1'b0;
    logic [DW-1:0]  cfg_value = '0;
    logic           insn_valid = 1'b0;
    logic [DW-1:0]  fetch_addr = '0, fetch_insn = '0, load_addr = '0, store_addr = '0, store_data = '0;
    logic [NUM_TRIG-1:0] fire;
    logic           trap_before, trap_after, enter_debug;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    dbg_trig_eval #(.DATA_W(DW)) u_dut (
        .clk, .rst, .cfg_we, .cfg_idx, .cfg_enable, .cfg_mtype, .cfg_sel,
        .cfg_timing, .cfg_action, .cfg_chain, .cfg_value, .insn_valid,
        .fetch_addr, .fetch_insn, .load_addr, .store_addr, .store_data,
        .fire, .trap_before, .trap_after, .enter_debug
    );

    // Expected word: {trap_before, trap_after, enter_debug, fire[9:0]}
    function automatic logic [12:0] ex(bit tb, bit ta, bit dbg, logic [9:0] f);
        return {tb, ta, dbg, f};
    endfunction

    task automatic chk(string req, logic [12:0] exp);
        logic [12:0] got;
        got = {trap_before, trap_after, enter_debug, fire};
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%b expected=%b", req, got, exp);
        end
    endtask

    task automatic wr(int idx, bit en, bit [1:0] mt, bit sel, bit tim, bit act, bit chn,
                      logic [DW-1:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = IDX_W'(idx); cfg_enable = en; cfg_mtype = mt;
        cfg_sel = sel; cfg_timing = tim; cfg_action = act; cfg_chain = chn; cfg_value = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic apply(bit v, logic [DW-1:0] fa, logic [DW-1:0] fi, logic [DW-1:0] la,
                         logic [DW-1:0] sa, logic [DW-1:0] sd);
        @(negedge clk);
        insn_valid = v; fetch_addr = fa; fetch_insn = fi;
        load_addr = la; store_addr = sa; store_data = sd;
        #1;
    endtask

    task automatic clear_all();
        for (int i = 0; i < NUM_TRIG; i++) wr(i, 0, 0, 0, 0, 0, 0, '0);
    endtask

    task automatic t_reset();
        apply(1, 0, 0, 0, 0, 0);
        chk("R1 reset quiet", ex(0, 0, 0, 10'b0));
    endtask

    task automatic t_fetch_eq();
        wr(0, 1, 2'd0, 0, 0, 0, 0, 16'h1234);
        apply(1, 16'h1234, 0, 0, 0, 0);
        chk("R3 R4 R9 fetch eq", ex(1, 0, 0, 10'b0000000001));
        apply(1, 16'h1235, 0, 0, 0, 0);
        chk("R3 fetch ne", ex(0, 0, 0, 10'b0));
        apply(0, 16'h1234, 0, 0, 0, 0);
        chk("R5 insn_valid low", ex(0, 0, 0, 10'b0));
        wr(1, 1, 2'd0, 1, 1, 0, 0, 16'hABCD);
        apply(1, 16'h0000, 16'hABCD, 0, 0, 0);
        chk("R4 R9 fetch insn select, after", ex(0, 1, 0, 10'b0000000010));
        clear_all();
    endtask

    task automatic t_ranges();
        wr(2, 1, 2'd2, 0, 0, 0, 0, 16'h0100);
        apply(1, 0, 0, 0, 16'h00FF, 0);
        chk("R3 ge below", ex(0, 0, 0, 10'b0));
        apply(1, 0, 0, 0, 16'h0100, 0);
        chk("R3 ge equal", ex(1, 0, 0, 10'b0000000100));
        apply(1, 0, 0, 0, 16'hFFFF, 0);
        chk("R3 ge max", ex(1, 0, 0, 10'b0000000100));
        wr(2, 1, 2'd3, 0, 0, 0, 0, 16'h0100);
        apply(1, 0, 0, 0, 16'h00FF, 0);
        chk("R3 lt below", ex(1, 0, 0, 10'b0000000100));
        apply(1, 0, 0, 0, 16'h0100, 0);
        chk("R3 lt equal", ex(0, 0, 0, 10'b0));
        wr(2, 1, 2'd1, 0, 0, 0, 0, 16'h0100);
        apply(1, 0, 0, 0, 16'h0100, 0);
        chk("R3 reserved type", ex(0, 0, 0, 10'b0));
        wr(3, 1, 2'd0, 1, 0, 1, 0, 16'h0055);
        apply(1, 0, 0, 0, 16'h0000, 16'h0055);
        chk("R4 R10 store data debug", ex(1, 0, 1, 10'b0000001000));
        clear_all();
    endtask

    task automatic t_load();
        wr(4, 1, 2'd0, 1, 0, 0, 0, 16'h0040);
        apply(1, 0, 0, 16'h0040, 0, 0);
        chk("R4 load data select never", ex(0, 0, 0, 10'b0));
        wr(4, 1, 2'd0, 0, 0, 0, 0, 16'h0040);
        apply(1, 0, 0, 16'h0040, 0, 0);
        chk("R4 load addr", ex(1, 0, 0, 10'b0000010000));
        clear_all();
    endtask

    task automatic t_chain();
        wr(0, 1, 2'd0, 0, 0, 0, 1, 16'h0010);
        wr(1, 1, 2'd0, 1, 0, 0, 0, 16'h0077);
        apply(1, 16'h0010, 16'h0000, 0, 0, 0);
        chk("R6 chain lower only", ex(0, 0, 0, 10'b0));
        apply(1, 16'h0000, 16'h0077, 0, 0, 0);
        chk("R6 chain upper only", ex(0, 0, 0, 10'b0));
        apply(1, 16'h0010, 16'h0077, 0, 0, 0);
        chk("R6 chain both", ex(1, 0, 0, 10'b0000000011));
        wr(1, 1, 2'd0, 1, 1, 0, 0, 16'h0077);
        apply(1, 16'h0010, 16'h0077, 0, 0, 0);
        chk("R7 timing veto", ex(0, 0, 0, 10'b0));
        wr(1, 0, 2'd0, 1, 0, 0, 0, 16'h0077);
        apply(1, 16'h0010, 16'h0077, 0, 0, 0);
        chk("R11 disabled member", ex(0, 0, 0, 10'b0));
        wr(0, 1, 2'd0, 0, 0, 0, 0, 16'h0010);
        wr(1, 1, 2'd0, 1, 0, 0, 1, 16'h0077);
        apply(1, 16'h0010, 16'h0000, 0, 0, 0);
        chk("R6 upper chain field ignored", ex(1, 0, 0, 10'b0000000001));
        clear_all();
    endtask

    task automatic t_store_pair();
        wr(2, 1, 2'd0, 0, 0, 0, 1, 16'h0200);
        wr(3, 1, 2'd0, 1, 0, 0, 0, 16'h0009);
        apply(1, 0, 0, 0, 16'h0200, 16'h0000);
        chk("R8 store pair lower alone", ex(1, 0, 0, 10'b0000000100));
        apply(1, 0, 0, 0, 16'h0000, 16'h0009);
        chk("R8 store pair upper alone", ex(1, 0, 0, 10'b0000001000));
        wr(3, 1, 2'd0, 1, 1, 0, 0, 16'h0009);
        apply(1, 0, 0, 0, 16'h0200, 16'h0009);
        chk("R8 R9 no veto, both flags", ex(1, 1, 0, 10'b0000001100));
        clear_all();
    endtask

    task automatic t_mixed();
        wr(8, 1, 2'd0, 0, 1, 1, 1, 16'h0030);
        wr(9, 1, 2'd3, 0, 1, 0, 0, 16'h0050);
        apply(1, 16'h0030, 0, 16'h0010, 0, 0);
        chk("R6 R10 fetch/load chain", ex(0, 1, 1, 10'b1100000000));
        apply(1, 16'h0030, 0, 16'h0060, 0, 0);
        chk("R6 fetch/load partial", ex(0, 0, 0, 10'b0));
        clear_all();
    endtask

    task automatic t_idx_range();
        wr(12, 1, 2'd0, 0, 0, 1, 1, 16'h0000);
        wr(15, 1, 2'd0, 0, 0, 1, 1, 16'h0000);
        apply(1, 0, 0, 0, 0, 0);
        chk("R2 out-of-range index", ex(0, 0, 0, 10'b0));
        wr(6, 1, 2'd0, 0, 0, 0, 0, 16'h0000);
        apply(1, 0, 0, 0, 0, 0);
        chk("R2 write takes effect", ex(1, 0, 0, 10'b0001000000));
        clear_all();
    endtask

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog expired got=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_fetch_eq();
        t_ranges();
        t_load();
        t_chain();
        t_store_pair();
        t_mixed();
        t_idx_range();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule